// File: doc/BRIEF.md
# Bit-Serial Integer ALU Datapath

This block evaluates 32-bit integer arithmetic, logic and comparison operations while holding only one bit of logic per function. After a start pulse, two operand words are captured into shift registers. One result bit is then formed per clock, least significant bit first, using a single full-adder cell and a carry flip-flop. This trades roughly 32 cycles of latency per operation for a datapath whose width does not grow with the word size.

Each operation names a destination. The result bits either shift back into the first-operand register, whose contents appear on the `result` port, or into a separate next-PC register that appears on the `npc` port. When the next-PC register is the target, the first-operand register rotates through a full turn and so returns to its original value. Zero, sign and signed-overflow flags are produced at the end of each operation. The zero flag comes from a running OR of the written bits, so no wide reduction tree is needed.

Top module: `bit_serial_alu`

## Requirements
- R1: While `rstN` is low and after its release, `busy`, `done`, `result`, `npc`, `zeroFlag`, `signFlag` and `ovfFlag` are all 0.
- R2: A `start` high at a rising edge while `busy` is low captures `opA`, `opB`, `opSel` and `destSel` and raises `busy`. `done` is high for exactly one cycle, in the cycle that follows the 32nd rising edge after the capturing edge; `busy` falls at that same edge.
- R3: `start` and operand changes while `busy` is high have no effect on the running operation's result, flags or completion time.
- R4: `opSel` 0 gives `opA + opB` and `opSel` 1 gives `opA - opB`, both modulo 2^32.
- R5: `opSel` 2, 3, 4 and 5 give bitwise AND, OR, XOR and NOR of the operands.
- R6: `opSel` 6 (signed) and 7 (unsigned) give 1 when `opA < opB` and 0 otherwise, with bits 31..1 of the written word zero.
- R7: At `done`, `ovfFlag` is 1 only for add or subtract whose two's-complement result overflowed; it is 0 for every other operation.
- R8: At `done`, `zeroFlag` is 1 exactly when the written 32-bit word is zero, and `signFlag` equals that word's bit 31.
- R9: With `destSel` = 0 the result is written to `result` and `npc` keeps its value. With `destSel` = 1 the result is written to `npc` and `result` shows the captured `opA` at `done`.
- R10: A `start` presented in the cycle where `done` is high is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when idle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code (see R4 to R6) |
| destSel | input | 1 | 0: write result register, 1: write next-PC register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | First-operand / result register |
| npc | output | 32 | Next-PC register |
| zeroFlag | output | 1 | Written word is zero |
| signFlag | output | 1 | Bit 31 of written word |
| ovfFlag | output | 1 | Signed overflow of add/subtract |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. A new start is driven exactly in the cycle where `done` is high. The bench then checks that the finished operation's result and flags are intact at that point, and that the second operation completes 32 edges later with its own correct values. A start asserted in the middle of a run is also exercised, so that the idle-only acceptance rule is separated from the back-to-back case.

// File: rtl/bit_serial_alu_pkg.sv
package bit_serial_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOR  = 3'd5,
    OP_SLT  = 3'd6,
    OP_SLTU = 3'd7
  } aluOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands this edge
    logic step;  // process one bit this edge
    logic last;  // this step handles the top bit
  } seqStrobe_t;

endpackage

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bit_serial_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitCnt;

  always_comb begin
    strb.load = start && !busy;
    strb.step = busy;
    strb.last = busy && (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
    end else begin
      done <= strb.last;
      if (strb.load) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (strb.last) begin
        busy <= 1'b0;
      end else if (busy) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bsa_bitcell.sv
module bsa_bitcell
  import bit_serial_alu_pkg::*;
(
  input  aluOp_e op,
  input  logic   aBit,
  input  logic   bBit,
  input  logic   cin,
  output logic   res,
  output logic   sum,
  output logic   cout
);
  logic invB;
  logic bEff;

  always_comb begin
    invB = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    bEff = bBit ^ invB;
    sum  = aBit ^ bEff ^ cin;
    cout = (aBit & bEff) | (cin & (aBit ^ bEff));
    case (op)
      OP_ADD, OP_SUB: res = sum;
      OP_AND:         res = aBit & bBit;
      OP_OR:          res = aBit | bBit;
      OP_XOR:         res = aBit ^ bBit;
      OP_NOR:         res = ~(aBit | bBit);
      default:        res = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath
  import bit_serial_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  seqStrobe_t   strb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [2:0]   opSel,
  input  logic         destSel,
  output logic [W-1:0] regA,
  output logic [W-1:0] regNpc,
  output logic         zeroFlag,
  output logic         signFlag,
  output logic         ovfFlag
);
  logic [W-1:0] regB;
  logic         carry;
  logic         destQ;
  logic         zeroAcc;
  aluOp_e       opQ;
  aluOp_e       opIn;

  logic cellRes, cellSum, cellCout;
  logic isSlt, isArith, invIn, wrBit, sltBit;

  bsa_bitcell cell_i (
    .op   (opQ),
    .aBit (regA[0]),
    .bBit (regB[0]),
    .cin  (carry),
    .res  (cellRes),
    .sum  (cellSum),
    .cout (cellCout)
  );

  always_comb begin
    opIn    = aluOp_e'(opSel);
    invIn   = (opIn == OP_SUB) || (opIn == OP_SLT) || (opIn == OP_SLTU);
    isSlt   = (opQ == OP_SLT) || (opQ == OP_SLTU);
    isArith = (opQ == OP_ADD) || (opQ == OP_SUB);
    wrBit   = isSlt ? 1'b0 : cellRes;
    // signed: sign of difference corrected by overflow; unsigned: borrow
    sltBit  = (opQ == OP_SLT) ? (cellSum ^ (carry ^ cellCout)) : !cellCout;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA     <= '0;
      regB     <= '0;
      regNpc   <= '0;
      carry    <= 1'b0;
      destQ    <= 1'b0;
      zeroAcc  <= 1'b0;
      opQ      <= OP_ADD;
      zeroFlag <= 1'b0;
      signFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else if (strb.load) begin
      regA    <= opA;
      regB    <= opB;
      carry   <= invIn;
      opQ     <= opIn;
      destQ   <= destSel;
      zeroAcc <= 1'b0;
    end else if (strb.step) begin
      regB    <= {1'b0, regB[W-1:1]};
      carry   <= cellCout;
      zeroAcc <= zeroAcc | wrBit;
      if (!destQ) begin
        regA <= {wrBit, regA[W-1:1]};
      end else begin
        regA   <= {regA[0], regA[W-1:1]};
        regNpc <= {wrBit, regNpc[W-1:1]};
      end
      if (strb.last) begin
        if (isSlt) begin
          if (!destQ) regA   <= {{(W-1){1'b0}}, sltBit};
          else        regNpc <= {{(W-1){1'b0}}, sltBit};
        end
        zeroFlag <= isSlt ? !sltBit : !(zeroAcc | wrBit);
        signFlag <= isSlt ? 1'b0 : wrBit;
        ovfFlag  <= isArith ? (carry ^ cellCout) : 1'b0;
      end
    end
  end

endmodule

// File: rtl/bit_serial_alu.sv
module bit_serial_alu
  import bit_serial_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [2:0]   opSel,
  input  logic         destSel,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic [W-1:0] npc,
  output logic         zeroFlag,
  output logic         signFlag,
  output logic         ovfFlag
);
  seqStrobe_t strb;

  bsa_ctrl #(.W(W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  bsa_datapath #(.W(W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .destSel  (destSel),
    .regA     (result),
    .regNpc   (npc),
    .zeroFlag (zeroFlag),
    .signFlag (signFlag),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         destSel,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] npc,
  input logic         zeroFlag,
  input logic         signFlag
);
  localparam int CW = ((W > 1) ? $clog2(W) : 1) + 1;

  logic [CW-1:0] runLen;
  logic          destL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
      destL  <= 1'b0;
    end else if (start && !busy) begin
      runLen <= '0;
      destL  <= destSel;
    end else if (busy) begin
      runLen <= runLen + 1'b1;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  done_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runLen == CW'(W)) && !busy);

  // R8
  zero_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !destL) |-> (zeroFlag == (result == '0)));

  // R8
  sign_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !destL) |-> (signFlag == result[W-1]));

  // R9
  zero_npc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && destL) |-> (zeroFlag == (npc == '0)));

  // R9
  npc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !destL) |=> $stable(npc));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(result) && $stable(npc)));

endmodule

bind bit_serial_alu bsa_checker #(.W(W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .destSel  (destSel),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .npc      (npc),
  .zeroFlag (zeroFlag),
  .signFlag (signFlag)
);

// File: tb/bit_serial_alu_tb_top.sv
module bit_serial_alu_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   opSel = '0;
  logic         destSel = 1'b0;
  logic         busy, done, zeroFlag, signFlag, ovfFlag;
  logic [W-1:0] result, npc;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [W-1:0] expA, expNpc;
  logic         expZ, expS, expV;

  always #5 clk = ~clk;

  bit_serial_alu #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .opSel(opSel), .destSel(destSel), .busy(busy), .done(done),
    .result(result), .npc(npc), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .ovfFlag(ovfFlag)
  );

  function automatic logic [W-1:0] modelRes(logic [W-1:0] a, logic [W-1:0] b,
                                            logic [2:0] op);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return ~(a | b);
      3'd6: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return (a < b) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic logic modelOvf(logic [W-1:0] a, logic [W-1:0] b,
                                    logic [2:0] op);
    logic [W-1:0] r;
    r = modelRes(a, b, op);
    if (op == 3'd0) return (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    if (op == 3'd1) return (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the falling edge after the accept edge.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] op, input logic dst);
    logic [W-1:0] r;
    r = modelRes(a, b, op);
    opA = a; opB = b; opSel = op; destSel = dst; start = 1'b1;
    if (dst) begin expNpc = r; expA = a; end
    else     begin expA = r; end
    expZ = (r == '0);
    expS = r[W-1];
    expV = modelOvf(a, b, op);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishOp(input int elapsed, input string tag);
    repeat (31 - elapsed) @(negedge clk);
    chk(!done && busy, "R2 done early", {30'd0, busy, done}, 32'd2);
    @(negedge clk);
    chk(done && !busy, "R2 done at edge 32", {30'd0, busy, done}, 32'd1);
    chk(result === expA, {tag, " result"}, result, expA);
    chk(npc === expNpc, {tag, " npc R9"}, npc, expNpc);
    chk(ovfFlag === expV, "R7 ovfFlag", {31'd0, ovfFlag}, {31'd0, expV});
    chk(zeroFlag === expZ, "R8 zeroFlag", {31'd0, zeroFlag}, {31'd0, expZ});
    chk(signFlag === expS, "R8 signFlag", {31'd0, signFlag}, {31'd0, expS});
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2:0] op, input logic dst, input string tag);
    launch(a, b, op, dst);
    finishOp(0, tag);
    @(negedge clk);
    chk(!done, "R2 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    expNpc = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 0 && npc == 0 && !zeroFlag && !signFlag && !ovfFlag,
        "R1 in reset", result | npc, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 0 && npc == 0 && !zeroFlag && !signFlag && !ovfFlag,
        "R1 after reset", result | npc, 32'd0);

    // R4 add/subtract corners
    runOp(32'd5, 32'd7, 3'd0, 1'b0, "R4 add");
    runOp(32'h7fffffff, 32'd1, 3'd0, 1'b0, "R4 add ovf");
    runOp(32'hffffffff, 32'd1, 3'd0, 1'b0, "R4 add wrap zero");
    runOp(32'd0, 32'd1, 3'd1, 1'b0, "R4 sub neg");
    runOp(32'h80000000, 32'd1, 3'd1, 1'b0, "R4 sub ovf");
    runOp(32'h12345678, 32'h12345678, 3'd1, 1'b0, "R4 sub zero");
    // R5 logic
    runOp(32'hf0f0cc33, 32'hff00aa55, 3'd2, 1'b0, "R5 and");
    runOp(32'hf0f0cc33, 32'hff00aa55, 3'd3, 1'b0, "R5 or");
    runOp(32'hf0f0cc33, 32'hff00aa55, 3'd4, 1'b0, "R5 xor");
    runOp(32'h0, 32'h0, 3'd5, 1'b0, "R5 nor");
    // R6 comparisons
    runOp(32'hffffffff, 32'd1, 3'd6, 1'b0, "R6 slt neg");
    runOp(32'hffffffff, 32'd1, 3'd7, 1'b0, "R6 sltu big");
    runOp(32'h80000000, 32'h7fffffff, 3'd6, 1'b0, "R6 slt ovf");
    runOp(32'd9, 32'd9, 3'd6, 1'b0, "R6 slt equal");
    runOp(32'd1, 32'd2, 3'd7, 1'b0, "R6 sltu small");
    // R9 next-PC destination, then result destination keeps npc
    runOp(32'h00000100, 32'd4, 3'd0, 1'b1, "R9 npc add");
    runOp(32'd3, 32'd8, 3'd7, 1'b1, "R9 npc sltu");
    runOp(32'h55, 32'h0f, 3'd2, 1'b0, "R9 npc hold");

    // R3 start while busy is ignored
    launch(32'd1000, 32'd24, 3'd1, 1'b0);
    repeat (10) @(negedge clk);
    opA = 32'hdeadbeef; opB = 32'h1; opSel = 3'd3; destSel = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    finishOp(13, "R3 ignored start");
    @(negedge clk);

    // R10 back-to-back: start in the done cycle
    launch(32'd40, 32'd2, 3'd0, 1'b0);
    finishOp(0, "R10 first");
    launch(32'h0000ffff, 32'hffff0000, 3'd4, 1'b0);
    finishOp(0, "R10 second");
    launch(32'hfffffffe, 32'd2, 3'd0, 1'b1);
    finishOp(0, "R10 third npc");
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] ra, rb;
      logic [2:0]   rop;
      logic         rd;
      ra  = $urandom();
      rb  = $urandom();
      rop = 3'($urandom_range(0, 7));
      rd  = 1'($urandom_range(0, 3) == 0);
      if ((i % 7) == 0) rb = ra;
      launch(ra, rb, rop, rd);
      finishOp(0, (rop < 2) ? "R4 random" : (rop < 6) ? "R5 random" : "R6 random");
      if ((i % 2) == 0) @(negedge clk);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule